// File: doc/BRIEF.md
# Stallable Sliding Window Generator

This block turns a raster stream of 8-bit luminance samples into a square neighbourhood of WIN x WIN pixels, which a downstream convolution filter can read. Each row of the image is held in a line delay, so the window can look back up to WIN-1 rows. A register array keeps the most recent WIN columns of every row. The 3x3 case uses two line delays. Larger odd windows come from a longer chain: the old sample read from one line delay is written into the next one. The horizontal blank and vertical blank flags are carried through with the same latency as the window.

Only one enable drives the whole datapath, and that enable is the active-video input. During horizontal blanking, vertical blanking, or any other gap, the window does not move. The next active pixel picks up exactly where the stream stopped. The column pointer shared by the line delays returns to zero at every rising edge of vertical blank. A short or broken line therefore cannot shift the alignment of the next frame. No padding is done at the image borders: taps that reach past the top or the left edge show whatever data is in storage.

Top module: `sliding_window_gen`

## Requirements
- R1: Tap (r,c) of the window sits in bits [(r*WIN+c)*8 +: 8] of `taps`, with r=0 as the top row and c=0 as the left column. Tap p11 is at index 0 and the bottom-right tap is at index WIN*WIN-1. Say the newest pixel is stream position n within a frame. Then tap (r,c) holds the pixel at position n - (WIN-1-r)*LINE_W - (WIN-1-c).
- R2: Each line delay is exactly LINE_W active pixels long, and LINE_W is a parameter with default 1920. The shared column pointer stays below LINE_W, and it wraps to zero after LINE_W-1.
- R3: The taps and all window storage advance only on cycles where `act_in` is high. Whenever `valid_out` is low, `taps` keeps its previous value.
- R4: `valid_out`, `href_out` and `vsync_out` equal `act_in`, `hblank_in` and `vblank_in` as they were two clock cycles earlier.
- R5: When `valid_out` is high, the bottom-right tap holds the pixel that was sampled with `act_in` high two cycles earlier.
- R6: On a cycle where `vblank_in` is high and was low on the cycle before, the column pointer restarts at zero. A partial line in front of the frame then leaves the new frame's window correct.
- R7: A synchronous reset on `rst` clears the three delayed flags, the taps and the column pointer to zero.
- R8: WIN is an odd parameter of 3 or more, and the design builds WIN-1 chained line delays. R1 holds in the same way for WIN=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Luminance sample |
| act_in | input | 1 | Active video; enables every datapath register |
| hblank_in | input | 1 | Horizontal blank flag |
| vblank_in | input | 1 | Vertical blank flag |
| taps | output | WIN*WIN*8 | Window taps, row-major, top-left at bit 0 |
| href_out | output | 1 | Horizontal blank delayed by two cycles |
| vsync_out | output | 1 | Vertical blank delayed by two cycles |
| valid_out | output | 1 | Active video delayed by two cycles; marks valid taps |

## Verification
The bench builds two copies with a line length of 16: one with a 3x3 window and one with a 5x5 window. Both receive the same 16x8 frames. A line length this short lets every tap be checked against a frame-local stream index in each active cycle. It also lets the line delays wrap many times, and it puts whole windows and border windows into every frame. Mid-line stalls at different columns test the hold behaviour. A five-pixel partial line placed before a frame tests the column restart on vertical blank.

// File: rtl/swg_pkg.sv
package swg_pkg;
    localparam int PIX_W = 8;
    typedef logic [PIX_W-1:0] pix_t;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/swg_line_delay.sv
// One row of history: read of the old sample and write of the new one share an address.
module swg_line_delay
    import swg_pkg::*;
#(
    parameter int LINE_W = 1920,
    localparam int AW = addr_bits(LINE_W)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  pix_t          wr_data,
    output pix_t          rd_data
);
    pix_t mem_q [LINE_W];

    always_ff @(posedge clk) begin
        if (en) begin
            mem_q[addr] <= wr_data;
        end
    end

    // Asynchronous read returns the sample stored one line ago at this column.
    assign rd_data = mem_q[addr];
endmodule

// File: rtl/swg_col_counter.sv
module swg_col_counter
    import swg_pkg::*;
#(
    parameter int LINE_W = 1920,
    localparam int AW = addr_bits(LINE_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          restart,
    output logic [AW-1:0] col
);
    localparam logic [AW-1:0] LAST = AW'(LINE_W - 1);

    logic [AW-1:0] col_d, col_q;

    always_comb begin
        col_d = col_q;
        if (restart) begin
            col_d = '0;
        end else if (en) begin
            col_d = (col_q == LAST) ? '0 : col_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign col = col_q;
endmodule

// File: rtl/swg_flag_delay.sv
// Fixed-latency shift of a small flag vector; bit 0 of the first stage is exported.
module swg_flag_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flags_in,
    output logic [W-1:0] flags_out,
    output logic         lead_bit0
);
    logic [DEPTH-1:0][W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = flags_in;
        for (int i = 1; i < DEPTH; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign flags_out = sr_q[DEPTH-1];
    assign lead_bit0 = sr_q[0][0];
endmodule

// File: rtl/sliding_window_gen.sv
module sliding_window_gen
    import swg_pkg::*;
#(
    parameter int WIN    = 3,
    parameter int LINE_W = 1920,
    localparam int AW    = addr_bits(LINE_W),
    localparam int NLINE = WIN - 1,
    localparam int TAP_W = WIN * WIN * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             act_in,
    input  logic             hblank_in,
    input  logic             vblank_in,
    output logic [TAP_W-1:0] taps,
    output logic             href_out,
    output logic             vsync_out,
    output logic             valid_out
);
    typedef logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win_t;

    typedef struct packed {
        logic vb;
        win_t win;
        win_t taps;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0]               col_idx;
    logic                        restart;
    logic                        win_moved;
    logic [2:0]                  flags_late;
    logic [NLINE-1:0][PIX_W-1:0] line_in;
    logic [NLINE-1:0][PIX_W-1:0] line_out;
    logic [WIN-1:0][PIX_W-1:0]   row_val;

    assign restart = vblank_in & ~st_q.vb;

    swg_col_counter #(.LINE_W(LINE_W)) u_col (
        .clk     (clk),
        .rst     (rst),
        .en      (act_in),
        .restart (restart),
        .col     (col_idx)
    );

    // Row WIN-1 is the live pixel; line k yields the row k+1 lines back.
    assign row_val[WIN-1] = pix_in;

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        if (k == 0) begin : g_head
            assign line_in[k] = pix_in;
        end else begin : g_link
            assign line_in[k] = line_out[k-1];
        end

        swg_line_delay #(.LINE_W(LINE_W)) u_line (
            .clk     (clk),
            .en      (act_in),
            .addr    (col_idx),
            .wr_data (line_in[k]),
            .rd_data (line_out[k])
        );

        assign row_val[WIN-2-k] = line_out[k];
    end

    swg_flag_delay #(.W(3), .DEPTH(2)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .flags_in  ({vblank_in, hblank_in, act_in}),
        .flags_out (flags_late),
        .lead_bit0 (win_moved)
    );

    always_comb begin
        st_d    = st_q;
        st_d.vb = vblank_in;
        if (act_in) begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN - 1; c++) begin
                    st_d.win[r][c] = st_q.win[r][c+1];
                end
                st_d.win[r][WIN-1] = row_val[r];
            end
        end
        if (win_moved) begin
            st_d.taps = st_q.win;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps      = st_q.taps;
    assign valid_out = flags_late[0];
    assign href_out  = flags_late[1];
    assign vsync_out = flags_late[2];
endmodule

// File: rtl/swg_checker.sv
module swg_checker #(
    parameter int WIN    = 3,
    parameter int LINE_W = 1920,
    parameter int PIX_W  = 8,
    localparam int AW    = swg_pkg::addr_bits(LINE_W)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       act_in,
    input logic                       hblank_in,
    input logic                       vblank_in,
    input logic                       href_out,
    input logic                       vsync_out,
    input logic                       valid_out,
    input logic [WIN*WIN*PIX_W-1:0]   taps,
    input logic [AW-1:0]              col
);
    a_r4_valid_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (valid_out == $past(act_in, 2)));

    a_r4_href_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (href_out == $past(hblank_in, 2)));

    a_r4_vsync_lag: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (vsync_out == $past(vblank_in, 2)));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !valid_out) |-> $stable(taps));

    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (vblank_in && !$past(vblank_in) && !$past(rst)) |=> (col == '0));

    a_r2_col_range: assert property (@(posedge clk) disable iff (rst)
        32'(col) < LINE_W);

    a_r7_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!valid_out && !href_out && !vsync_out && col == '0 && taps == '0));
endmodule

bind sliding_window_gen swg_checker #(
    .WIN    (WIN),
    .LINE_W (LINE_W),
    .PIX_W  (swg_pkg::PIX_W)
) u_swg_checker (
    .clk       (clk),
    .rst       (rst),
    .act_in    (act_in),
    .hblank_in (hblank_in),
    .vblank_in (vblank_in),
    .href_out  (href_out),
    .vsync_out (vsync_out),
    .valid_out (valid_out),
    .taps      (taps),
    .col       (col_idx)
);

// File: tb/test_sliding_window_gen.sv
module test_sliding_window_gen;
    localparam int LW   = 16;
    localparam int ROWS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix = '0;
    logic       act = 1'b0, hb = 1'b0, vb = 1'b0;

    logic [71:0]  t3;
    logic [199:0] t5;
    logic v3, h3, s3, v5, h5, s5;

    always #4 clk = ~clk;

    sliding_window_gen #(.WIN(3), .LINE_W(LW)) i_sliding_window_gen (
        .clk(clk), .rst(rst), .pix_in(pix), .act_in(act), .hblank_in(hb),
        .vblank_in(vb), .taps(t3), .href_out(h3), .vsync_out(s3), .valid_out(v3)
    );

    sliding_window_gen #(.WIN(5), .LINE_W(LW)) i_sliding_window_gen_5 (
        .clk(clk), .rst(rst), .pix_in(pix), .act_in(act), .hblank_in(hb),
        .vblank_in(vb), .taps(t5), .href_out(h5), .vsync_out(s5), .valid_out(v5)
    );

    int checks = 0, fails = 0;
    int gn = 0, cur_m = 0, frame_no = -1;
    logic [7:0] fr [256];
    logic h1_act = 0, h2_act = 0, h1_hb = 0, h2_hb = 0, h1_vb = 0, h2_vb = 0;
    int   h1_m = 0, h2_m = 0, h1_f = 0, h2_f = 0;
    logic last_vb = 1'b0;
    logic [199:0] prev3 = '0, prev5 = '0;
    bit checking = 0;

    function automatic logic [7:0] gpix(input int n);
        return 8'(n * 29 + (n / 16) * 7 + 3);
    endfunction

    function automatic string lab(input int win, input int r, input int c, input int f);
        if (f >= 1 && r < win - 1) return "R6";
        if (r == win - 1 && c == win - 1) return "R5";
        if (win == 5) return "R8";
        if (r < win - 1) return "R2";
        return "R1";
    endfunction

    task automatic note(input bit ok, input string req, input string what,
                        input logic [199:0] got, input logic [199:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp_v);
        end
    endtask

    task automatic check_inst(input int win, input logic [199:0] t, input logic v,
                              input logic h, input logic s, ref logic [199:0] prev);
        note(v == h2_act, "R4", $sformatf("valid win%0d", win), 200'(v), 200'(h2_act));
        note(h == h2_hb,  "R4", $sformatf("href win%0d", win),  200'(h), 200'(h2_hb));
        note(s == h2_vb,  "R4", $sformatf("vsync win%0d", win), 200'(s), 200'(h2_vb));
        if (v) begin
            for (int r = 0; r < win; r++) begin
                for (int c = 0; c < win; c++) begin
                    int idx;
                    logic [7:0] got;
                    idx = h2_m - (win - 1 - r) * LW - (win - 1 - c);
                    if (idx >= 0) begin
                        got = t[(r * win + c) * 8 +: 8];
                        note(got == fr[idx], lab(win, r, c, h2_f),
                             $sformatf("win%0d tap(%0d,%0d) pos %0d", win, r, c, h2_m),
                             200'(got), 200'(fr[idx]));
                    end
                end
            end
        end else begin
            note(t == prev, "R3", $sformatf("hold win%0d", win), t, prev);
        end
        prev = t;
    endtask

    task automatic step(input logic a, input logic hbl, input logic vbl);
        @(negedge clk);
        if (checking) begin
            check_inst(3, 200'(t3), v3, h3, s3, prev3);
            check_inst(5, t5, v5, h5, s5, prev5);
        end
        act = a;
        hb  = hbl;
        vb  = vbl;
        if (vbl && !last_vb) begin
            cur_m = 0;
            frame_no++;
        end
        last_vb = vbl;
        h2_act = h1_act; h2_hb = h1_hb; h2_vb = h1_vb; h2_m = h1_m; h2_f = h1_f;
        h1_act = a;      h1_hb = hbl;   h1_vb = vbl;   h1_m = cur_m; h1_f = frame_no;
        if (a) begin
            pix = gpix(gn);
            fr[cur_m] = pix;
            gn++;
            cur_m++;
        end
    endtask

    task automatic frame(input int stall_col);
        repeat (4) step(1'b0, 1'b0, 1'b1);
        for (int row = 0; row < ROWS; row++) begin
            repeat (3) step(1'b0, 1'b1, 1'b0);
            for (int col = 0; col < LW; col++) begin
                if (col == stall_col) repeat (2) step(1'b0, 1'b0, 1'b0);
                step(1'b1, 1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R7: reset dominates even with every input asserted
        act = 1'b1; hb = 1'b1; vb = 1'b1; pix = 8'h55;
        repeat (3) @(negedge clk);
        note(v3 == 0 && h3 == 0 && s3 == 0, "R7", "flags win3", 200'({v3, h3, s3}), '0);
        note(v5 == 0 && h5 == 0 && s5 == 0, "R7", "flags win5", 200'({v5, h5, s5}), '0);
        note(t3 == '0, "R7", "taps win3", 200'(t3), '0);
        note(t5 == '0, "R7", "taps win5", t5, '0);
        rst = 1'b0; act = 1'b0; hb = 1'b0; vb = 1'b0;
        checking = 1;

        frame(5);
        repeat (3) step(1'b0, 1'b1, 1'b0);
        repeat (5) step(1'b1, 1'b0, 1'b0);  // partial line before next frame (R6)
        frame(9);
        frame(13);
        repeat (6) step(1'b0, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule